// File: doc/BRIEF.md
# Twiddle Table Index Generator

This block produces, one per clock, the address into a combined sine/cosine table for a direct (non-fast) discrete Fourier transform of one frequency bin. A bin index k and a transform length N are applied together with a start pulse. The block then steps a sample counter n from 0 up to N−1 and presents the table address (n·k) mod N on each beat. N may be any value from 1 to 2^W−1 and does not have to be a power of two. The address selects a sine word and a cosine word from the same table entry.

No multiplier or divider is used. The address is advanced each beat by adding k and subtracting N once when the sum reaches N. A bin index that is not below N is first brought into range by a serial remainder unit that takes one cycle per bit of k. A stall input pauses the stepping with all position state kept intact. A flag marks the final sample of the bin, and the block then waits for the next start.

Top module: `twi_addr_gen`

## Requirements
- R1: While and directly after reset, `valid_o` and `last_o` are low and `addr_o` is 0.
- R2: After an accepted start (`start_i` high with `len_n_i` nonzero), exactly N beats follow, a beat being a cycle with `valid_o` high. Beat number n (counting from 0) carries `addr_o` = (n·k) mod N, with the beats in rising n. `bin_k_i` and `len_n_i` are sampled only in the start cycle.
- R3: On every beat, `addr_o` is below the N captured at start.
- R4: A bin index k of N or more gives the same beats as k mod N.
- R5: `last_o` is high on the beat for n = N−1 and on no other cycle. It is never high without `valid_o`. After it, `valid_o` stays low until the next accepted start.
- R6: While `stall_i` is high, `valid_o` is low, neither n nor `addr_o` changes, and the sequence resumes where it stopped once `stall_i` falls.
- R7: A start with `len_n_i` equal to 0 is ignored. It produces no beats and does not disturb a sequence in progress.
- R8: An accepted start during a sequence, or during range reduction, drops the old sequence. No beat appears in the cycle after that start, and the new sequence then runs in full.
- R9: With `stall_i` low, the first beat occurs in the cycle that follows the W+1-th rising edge after the edge that samples the start (11 edges for W = 10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a new bin; samples bin_k_i and len_n_i |
| bin_k_i | input | W | Frequency bin index k |
| len_n_i | input | W | Transform length N (0 means the start is ignored) |
| stall_i | input | 1 | Pause stepping, keeping position |
| addr_o | output | W | Sine/cosine table address (n·k) mod N |
| valid_o | output | 1 | addr_o holds a beat this cycle |
| last_o | output | 1 | This beat is sample n = N−1 |

## Verification
The bench aims at the modular wrap. With k just under N, the sum wraps nearly every beat, and a design that compares with the wrong bound or forgets the subtraction gives addresses at or beyond N. For bin indices far above N (1023 against 1000 or against 1), a reduction that stopped early or ran one bit too many would shift every later address. The bench also covers k = 0, N = 1, and the full length N = 1023. Random stalls are checked against a scoreboard, which catches a design that drops or repeats a beat around a pause. A restart in mid-sequence and a zero-length start show whether stale beats leak out or whether a bogus start kills a running bin.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int unsigned TWI_W = 10;

  typedef enum logic {
    STEP_IDLE = 1'b0,
    STEP_RUN  = 1'b1
  } step_state_t;
endpackage

// File: rtl/twi_rst_sync.sv
module twi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/twi_kmod.sv
// Serial restoring remainder: k mod N in W cycles, one bit of k per cycle.
module twi_kmod #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] k_i,
  input  logic [W-1:0] n_i,
  output logic         done_o,
  output logic         busy_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

  logic          act_q,   act_d;
  logic          done_q,  done_d;
  logic [CW-1:0] cnt_q,   cnt_d;
  logic [W-1:0]  shift_q, shift_d;
  logic [W-1:0]  rem_q,   rem_d;
  logic [W:0]    trial;
  logic [W:0]    trial_sub;
  logic          fits;
  logic          en;

  always_comb begin
    trial     = {rem_q, shift_q[W-1]};
    fits      = trial >= {1'b0, n_i};
    trial_sub = trial - {1'b0, n_i};
  end

  always_comb begin
    act_d   = act_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    rem_d   = rem_q;
    if (start_i) begin
      act_d   = 1'b1;
      cnt_d   = '0;
      shift_d = k_i;
      rem_d   = '0;
    end else if (act_q) begin
      shift_d = {shift_q[W-2:0], 1'b0};
      rem_d   = fits ? trial_sub[W-1:0] : trial[W-1:0];
      cnt_d   = cnt_q + CW'(1);
      if (cnt_q == LAST_BIT) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  assign en = start_i | act_q | done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      rem_q   <= '0;
    end else if (en) begin
      act_q   <= act_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      rem_q   <= rem_d;
    end
  end

  assign done_o = done_q;
  assign busy_o = act_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/twi_step.sv
// Sample counter and modular address accumulator.
module twi_step
  import twi_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] kr_i,
  input  logic [W-1:0] n_i,
  input  logic         stall_i,
  output logic [W-1:0] addr_o,
  output logic         valid_o,
  output logic         last_o,
  output logic         run_o
);
  step_state_t  st_q,   st_d;
  logic [W-1:0] addr_q, addr_d;
  logic [W-1:0] idx_q,  idx_d;
  logic [W:0]   sum;
  logic [W:0]   sum_sub;
  logic         wrap;
  logic         fire;
  logic         at_end;
  logic         en;

  always_comb begin
    sum     = {1'b0, addr_q} + {1'b0, kr_i};
    wrap    = sum >= {1'b0, n_i};
    sum_sub = sum - {1'b0, n_i};
    at_end  = idx_q == (n_i - W'(1));
    fire    = (st_q == STEP_RUN) && !stall_i;
  end

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    idx_d  = idx_q;
    if (clr_i) begin
      st_d = STEP_IDLE;
    end else if (load_i) begin
      st_d   = STEP_RUN;
      addr_d = '0;
      idx_d  = '0;
    end else if (fire) begin
      if (at_end) begin
        st_d = STEP_IDLE;
      end else begin
        idx_d  = idx_q + W'(1);
        addr_d = wrap ? sum_sub[W-1:0] : sum[W-1:0];
      end
    end
  end

  assign en = clr_i | load_i | fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= STEP_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
    end else if (en) begin
      st_q   <= st_d;
      addr_q <= addr_d;
      idx_q  <= idx_d;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = fire;
  assign last_o  = fire && at_end;
  assign run_o   = st_q == STEP_RUN;
endmodule

// File: rtl/twi_addr_gen.sv
module twi_addr_gen #(
  parameter int unsigned W = twi_pkg::TWI_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] bin_k_i,
  input  logic [W-1:0] len_n_i,
  input  logic         stall_i,
  output logic [W-1:0] addr_o,
  output logic         valid_o,
  output logic         last_o
);
  logic         rst_n_s;
  logic         start_ok;
  logic [W-1:0] len_q;
  logic         red_done;
  logic         red_busy;
  logic [W-1:0] k_red;
  logic         step_run;

  twi_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  assign start_ok = start_i && (len_n_i != '0);

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)      len_q <= '0;
    else if (start_ok) len_q <= len_n_i;
  end

  twi_kmod #(.W(W)) u_kmod (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .start_i (start_ok),
    .k_i     (bin_k_i),
    .n_i     (len_q),
    .done_o  (red_done),
    .busy_o  (red_busy),
    .rem_o   (k_red)
  );

  twi_step #(.W(W)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .clr_i   (start_ok),
    .load_i  (red_done),
    .kr_i    (k_red),
    .n_i     (len_q),
    .stall_i (stall_i),
    .addr_o  (addr_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .run_o   (step_run)
  );
endmodule

// File: rtl/twi_addr_gen_chk.sv
module twi_addr_gen_chk #(
  parameter int unsigned W = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] len_n_i,
  input logic         stall_i,
  input logic [W-1:0] addr_o,
  input logic         valid_o,
  input logic         last_o,
  input logic [W-1:0] len_q,
  input logic         step_run,
  input logic         red_busy
);
  p_first_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_run) |-> addr_o == '0);

  p_addr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> addr_o < len_q);

  p_last_with_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_idle_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  p_stall_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !valid_o);

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && step_run && !start_i) |=> $stable(addr_o));

  p_len0_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_n_i == '0 && !step_run && !red_busy) |=> !valid_o);

  p_restart_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_n_i != '0) |=> !valid_o);
endmodule

bind twi_addr_gen twi_addr_gen_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .len_n_i  (len_n_i),
  .stall_i  (stall_i),
  .addr_o   (addr_o),
  .valid_o  (valid_o),
  .last_o   (last_o),
  .len_q    (len_q),
  .step_run (step_run),
  .red_busy (red_busy)
);

// File: tb/twi_addr_gen_tb.sv
`timescale 1ns/1ps
module twi_addr_gen_tb;
  localparam int W = 10;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] bin_k;
  logic [W-1:0] len_n;
  logic         stall;
  logic [W-1:0] addr;
  logic         valid;
  logic         last;

  int tests  = 0;
  int fails  = 0;
  int beats  = 0;
  logic stall_en    = 1'b0;
  logic stall_force = 1'b0;
  logic [7:0] lfsr  = 8'hA5;

  typedef struct { int a; logic l; } exp_t;
  exp_t exp_q[$];

  twi_addr_gen #(.W(W)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .bin_k_i (bin_k),
    .len_n_i (len_n),
    .stall_i (stall),
    .addr_o  (addr),
    .valid_o (valid),
    .last_o  (last)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Stall driver
  initial begin
    stall = 1'b0;
    forever begin
      @(posedge clk); #1;
      lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      stall = stall_force | (stall_en & lfsr[0] & lfsr[2]);
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (last && !valid) check("R5 last without valid", 1, 0);
        if (valid) begin
          beats++;
          if (exp_q.size() == 0) begin
            check("R5 unexpected beat", 1, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check("R2 R3 R4 addr", int'(addr), e.a);
            check("R5 last flag", int'(last), int'(e.l));
          end
        end
      end
    end
  end

  task automatic push_bin(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.a = (i * k) % n;
      e.l = (i == n - 1);
      exp_q.push_back(e);
    end
  endtask

  task automatic pulse_start(input int k, input int n);
    @(posedge clk); #1;
    start = 1'b1;
    bin_k = W'(k);
    len_n = W'(n);
    @(posedge clk); #1;
    start = 1'b0;
    bin_k = W'(k ^ 'h2AA);
    len_n = W'(n ^ 'h155);
  endtask

  task automatic run_bin(input int k, input int n);
    int guard;
    beats = 0;
    push_bin(k, n);
    pulse_start(k, n);
    guard = 0;
    while (beats < n && guard < 6000) begin
      @(posedge clk);
      guard++;
    end
    repeat (20) @(posedge clk);
    check("R2 beat count", beats, n);
    check("R2 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    start = 1'b0;
    bin_k = '0;
    len_n = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", int'(valid), 0);
    check("R1 last in reset", int'(last), 0);
    check("R1 addr in reset", int'(addr), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 valid after reset", int'(valid), 0);
    check("R1 addr after reset", int'(addr), 0);

    // R9 latency, no stall
    begin
      int cnt;
      beats = 0;
      push_bin(3, 10);
      pulse_start(3, 10);
      cnt = 0;
      while (cnt < 40) begin
        @(negedge clk);
        cnt++;
        if (valid) break;
      end
      check("R9 first beat latency", cnt, W + 2);
      repeat (30) @(posedge clk);
      check("R2 count k=3 N=10", beats, 10);
    end

    run_bin(0, 7);
    run_bin(1, 1);
    run_bin(999, 1000);            // wrap nearly every beat (R3)
    run_bin(1023, 1000);           // R4: k reduced to 23
    run_bin(1023, 1);              // R4: k reduced to 0
    run_bin(600, 37);              // R4 non power of two
    stall_en = 1'b1;               // R6 random stalls
    run_bin(700, 513);
    run_bin(7, 12);
    run_bin(5, 1023);
    stall_en = 1'b0;

    // R7: zero-length start while idle
    beats = 0;
    pulse_start(5, 0);
    repeat (30) @(posedge clk);
    check("R7 zero length idle", beats, 0);

    // R7: zero-length start during a run does not disturb it
    run_bin_with_zero_start();

    // R8: restart mid sequence
    beats = 0;
    push_bin(2, 9);
    pulse_start(2, 9);
    while (beats < 3) @(negedge clk);
    @(posedge clk); #1;
    stall_force = 1'b1;
    @(posedge clk); #1;
    exp_q.delete();
    beats = 0;
    push_bin(4, 11);
    pulse_start(4, 11);
    @(posedge clk); #1;
    stall_force = 1'b0;
    repeat (60) @(posedge clk);
    check("R8 restart beat count", beats, 11);
    check("R8 scoreboard drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic run_bin_with_zero_start();
    beats = 0;
    push_bin(6, 40);
    pulse_start(6, 40);
    repeat (20) @(posedge clk);
    pulse_start(9, 0);
    repeat (80) @(posedge clk);
    check("R7 run survives zero start", beats, 40);
    check("R7 scoreboard drained", exp_q.size(), 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule